// File: doc/BRIEF.md
# Host Bridge Control Register File

This block is the 32-bit control register bank that sits behind the CPU side of a CPU-to-PCI host bridge. It occupies a 4 KB window. The word slot is picked from the low twelve address bits, and higher address bits alias. Each class of register applies its own write mask. Writing the low half of an address-decode pair also loads the matching remap register. The error-report, ECC and barrier slots are read-only. The barrier slots return a fixed marker word whenever they are read.

The block also holds the configuration-address latch that the bridge uses to form PCI configuration cycles. From the first I/O low/high decode pair it derives the base address and the size of the PCI I/O window, which neighbouring address-decode logic consumes. A build-time option serves big-endian hosts. With it set, write data is byte-reversed before it is stored and read data is byte-reversed before it is returned. The reset values of the CPU configuration and PCI command registers also change with this option.

The bus side is a single-cycle port. A write takes effect on the clock edge at which it is presented. A read returns registered data on the following cycle, flagged by `rvalid`.

Top module: `hbr_regfile`

## Requirements
- R1: The slot is selected by byte address bits [11:2] only. Address bits at 12 and above, and bits [1:0], are ignored, so an access at byte address 0x1CF8 or 0xFFFFFCF8 reaches the same register as 0xCF8.
- R2: A write to a low-decode register stores the value ANDed with 0x7FFF. The same write stores the value ANDed with 0x7FF into the paired remap register. The low-decode byte offsets are 0x048, 0x058, 0x080, 0x090, 0x0A0 and 0x0B0, and the paired remap offsets are 0x0F0, 0x0F8, 0x100, 0x108, 0x110 and 0x118 in the same order.
- R3: A write to a high-decode register stores the value ANDed with 0x7F. The high-decode offsets are 0x050, 0x060, 0x088, 0x098, 0x0A8 and 0x0B8, paired in order with the low-decode list. A direct write to a remap register stores the value ANDed with 0x7FF and leaves its low-decode partner unchanged.
- R4: A write to either PCI command register (0xC00, 0xC80) stores the value ANDed with 0x0401FC0F. A write to the configuration-address latch (0xCF8) stores the value ANDed with 0x80FFFFFC.
- R5: Writes are ignored at the error-report slots (0x070, 0x078, 0x128, 0x130, 0x138), the ECC slots (0x480 to 0x490), the multi-device slot (0x120) and the barrier slots. Error slots 0x128 and 0x130 read 0xFFFFFFFF, 0x138 reads 0x000000FF, and the other slots in this group read 0. Such writes leave the I/O window outputs unchanged.
- R6: A read of either barrier slot (0x0C0, 0x0C8) returns 0xC000FFEE.
- R7: `io_base` equals the 0x048 low-decode value times 2^21. `io_size` equals ((0x050 high value + 1) − (low value AND 0x7F)) times 2^21, taken modulo 2^36. Both are 36 bits wide and follow a write from the cycle after it.
- R8: After reset with little-endian data, the registers read as follows: CPU configuration (0x000) 0x800, 0x048 0x80, 0x050 0x0F, both PCI command registers 0x00010001, the SDRAM bank parameter slots (0x44C to 0x458) 5, and the latch 0. With the big-endian option, the CPU configuration and PCI command registers reset to 0.
- R9: `rvalid` is high in exactly the cycle after a read request, and `rdata` holds the data of that read in that cycle. A write request does not raise `rvalid`.
- R10: The CPU configuration and SDRAM bank parameter registers keep all 32 written bits. Any slot not named in these requirements (for example 0x800 and 0xCFC) reads 0 and drops writes.
- R11: With the big-endian option, write data is byte-reversed before masking and storage, and read data, including the barrier marker, is byte-reversed on return. For example, writing 0x22110000 to 0x048 sets the low-decode value to 0x1122.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request for this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W (32) | Byte address; bits [11:2] select the slot |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | Read data valid, one cycle after a read request |
| io_base | output | WIN_W (36) | PCI I/O window base address |
| io_size | output | WIN_W (36) | PCI I/O window size |

## Verification
The hardest cases to reach are those where the stored value differs from what a plain register would hold. One is the wrap of the window size when the high bound is below the masked low bound. The other is the big-endian path, where a single write is reversed, masked to 15 and to 11 bits, and mirrored. The bench builds a little-endian and a big-endian instance on the same bus, so each write lands in both, and it chooses write values whose reversed bytes fall inside the decode masks. Because a plain write-then-read round trip cannot show the reversal on a full-width register, the big-endian checks use the masked decode registers, the window base and the fixed marker. The wrap case is reached by writing a low bound of 0x7F and a high bound of 0.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

  localparam int WORD_W    = 32;
  localparam int IDX_W     = 10;
  localparam int NUM_WIN   = 6;
  localparam int LOW_W     = 15;
  localparam int HIGH_W    = 7;
  localparam int REMAP_W   = 11;
  localparam int WIN_SHIFT = 21;
  localparam int NUM_BANK  = 4;
  localparam int NUM_CMD   = 2;

  localparam logic [WORD_W-1:0] CMD_MASK   = 32'h0401_FC0F;
  localparam logic [WORD_W-1:0] CFGA_MASK  = 32'h80FF_FFFC;
  localparam logic [WORD_W-1:0] SYNC_MARK  = 32'hC000_FFEE;
  localparam logic [WORD_W-1:0] BANK_RST   = 32'h0000_0005;
  localparam logic [WORD_W-1:0] CPU_RST_LE = 32'h0000_0800;
  localparam logic [WORD_W-1:0] CMD_RST_LE = 32'h0001_0001;

  typedef enum logic [3:0] {
    RC_NONE, RC_CPU, RC_MULTI, RC_LOW, RC_HIGH, RC_REMAP,
    RC_ERR, RC_SYNC, RC_ECC, RC_BANK, RC_CMD, RC_CFGA
  } rclass_e;

  typedef struct packed {
    rclass_e    cls;
    logic [2:0] sel;
  } rsel_t;

  function automatic logic [WORD_W-1:0] bswap32(logic [WORD_W-1:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [LOW_W-1:0] low_rst(int k);
    case (k)
      0: return 15'h0080;
      1: return 15'h0090;
      2: return 15'h0790;
      3: return 15'h0100;
      4: return 15'h0110;
      default: return 15'h0120;
    endcase
  endfunction

  function automatic logic [HIGH_W-1:0] high_rst(int k);
    case (k)
      0, 3: return 7'h0F;
      5:    return 7'h2F;
      default: return 7'h1F;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] err_value(logic [2:0] sel);
    case (sel)
      3'd2, 3'd3: return 32'hFFFF_FFFF;
      3'd4:       return 32'h0000_00FF;
      default:    return 32'h0;
    endcase
  endfunction

  function automatic rsel_t classify(logic [IDX_W-1:0] idx);
    rsel_t r;
    r.cls = RC_NONE;
    r.sel = 3'd0;
    case (idx)
      10'h000: r.cls = RC_CPU;
      10'h048: r.cls = RC_MULTI;
      10'h012: begin r.cls = RC_LOW;   r.sel = 3'd0; end
      10'h016: begin r.cls = RC_LOW;   r.sel = 3'd1; end
      10'h020: begin r.cls = RC_LOW;   r.sel = 3'd2; end
      10'h024: begin r.cls = RC_LOW;   r.sel = 3'd3; end
      10'h028: begin r.cls = RC_LOW;   r.sel = 3'd4; end
      10'h02C: begin r.cls = RC_LOW;   r.sel = 3'd5; end
      10'h014: begin r.cls = RC_HIGH;  r.sel = 3'd0; end
      10'h018: begin r.cls = RC_HIGH;  r.sel = 3'd1; end
      10'h022: begin r.cls = RC_HIGH;  r.sel = 3'd2; end
      10'h026: begin r.cls = RC_HIGH;  r.sel = 3'd3; end
      10'h02A: begin r.cls = RC_HIGH;  r.sel = 3'd4; end
      10'h02E: begin r.cls = RC_HIGH;  r.sel = 3'd5; end
      10'h03C: begin r.cls = RC_REMAP; r.sel = 3'd0; end
      10'h03E: begin r.cls = RC_REMAP; r.sel = 3'd1; end
      10'h040: begin r.cls = RC_REMAP; r.sel = 3'd2; end
      10'h042: begin r.cls = RC_REMAP; r.sel = 3'd3; end
      10'h044: begin r.cls = RC_REMAP; r.sel = 3'd4; end
      10'h046: begin r.cls = RC_REMAP; r.sel = 3'd5; end
      10'h01C: begin r.cls = RC_ERR;   r.sel = 3'd0; end
      10'h01E: begin r.cls = RC_ERR;   r.sel = 3'd1; end
      10'h04A: begin r.cls = RC_ERR;   r.sel = 3'd2; end
      10'h04C: begin r.cls = RC_ERR;   r.sel = 3'd3; end
      10'h04E: begin r.cls = RC_ERR;   r.sel = 3'd4; end
      10'h030, 10'h032: r.cls = RC_SYNC;
      10'h120, 10'h121, 10'h122, 10'h123, 10'h124: r.cls = RC_ECC;
      10'h113: begin r.cls = RC_BANK;  r.sel = 3'd0; end
      10'h114: begin r.cls = RC_BANK;  r.sel = 3'd1; end
      10'h115: begin r.cls = RC_BANK;  r.sel = 3'd2; end
      10'h116: begin r.cls = RC_BANK;  r.sel = 3'd3; end
      10'h300: begin r.cls = RC_CMD;   r.sel = 3'd0; end
      10'h320: begin r.cls = RC_CMD;   r.sel = 3'd1; end
      10'h33E: r.cls = RC_CFGA;
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/hbr_decode.sv
module hbr_decode
  import hbr_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output rsel_t            hit
);
  assign hit = classify(idx);
endmodule

// File: rtl/hbr_byteorder.sv
module hbr_byteorder #(
  parameter int W    = 32,
  parameter bit SWAP = 1'b0
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NBYTES = W / 8;

  if (SWAP) begin : g_swap
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign dout[8*b +: 8] = din[8*(NBYTES-1-b) +: 8];
    end
  end else begin : g_pass
    assign dout = din;
  end
endmodule

// File: rtl/hbr_window.sv
module hbr_window #(
  parameter int LOW_W  = 15,
  parameter int HIGH_W = 7,
  parameter int SHIFT  = 21,
  parameter int WIN_W  = 36
) (
  input  logic [LOW_W-1:0]  low,
  input  logic [HIGH_W-1:0] high,
  output logic [WIN_W-1:0]  base,
  output logic [WIN_W-1:0]  size
);
  function automatic logic [WIN_W-1:0] win_base(logic [LOW_W-1:0] lo);
    return WIN_W'(lo) << SHIFT;
  endfunction

  function automatic logic [WIN_W-1:0] win_size(logic [LOW_W-1:0] lo,
                                                logic [HIGH_W-1:0] hi);
    logic [WIN_W-1:0] span;
    span = WIN_W'(hi) + WIN_W'(1) - WIN_W'(lo[HIGH_W-1:0]);
    return span << SHIFT;
  endfunction

  assign base = win_base(low);
  assign size = win_size(low, high);
endmodule

// File: rtl/hbr_regfile.sv
module hbr_regfile
  import hbr_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int WINDOW_BYTES = 4096,
  parameter bit BIG_ENDIAN   = 1'b0,
  parameter int WIN_W        = 36,
  parameter int IO_WIN       = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rvalid,
  output logic [WIN_W-1:0]  io_base,
  output logic [WIN_W-1:0]  io_size
);
  localparam int WIN_AW = $clog2(WINDOW_BYTES);
  localparam logic [WORD_W-1:0] CPU_RST = BIG_ENDIAN ? 32'h0 : CPU_RST_LE;
  localparam logic [WORD_W-1:0] CMD_RST = BIG_ENDIAN ? 32'h0 : CMD_RST_LE;
  localparam logic [WORD_W-1:0] SYNC_SEEN = BIG_ENDIAN ? bswap32(SYNC_MARK) : SYNC_MARK;

  // named bus events
  logic wr_ev, rd_ev;
  assign wr_ev = req & we;
  assign rd_ev = req & ~we;

  logic [IDX_W-1:0] idx;
  assign idx = addr[WIN_AW-1:2];

  logic unused_addr_bits;
  assign unused_addr_bits = ^{addr[ADDR_W-1:WIN_AW], addr[1:0]};

  rsel_t dec;
  hbr_decode u_decode (.idx(idx), .hit(dec));

  logic [WORD_W-1:0] wval;
  hbr_byteorder #(.W(WORD_W), .SWAP(BIG_ENDIAN)) u_wr_order (.din(wdata), .dout(wval));

  // plain-width registers
  logic [WORD_W-1:0] cpu_q;
  logic [WORD_W-1:0] cfga_q;
  logic [NUM_BANK-1:0][WORD_W-1:0] bank_q;
  logic [NUM_CMD-1:0][WORD_W-1:0]  cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_q  <= CPU_RST;
      cfga_q <= '0;
      for (int i = 0; i < NUM_BANK; i++) bank_q[i] <= BANK_RST;
      for (int i = 0; i < NUM_CMD; i++)  cmd_q[i]  <= CMD_RST;
    end else if (wr_ev) begin
      case (dec.cls)
        RC_CPU:  cpu_q <= wval;
        RC_BANK: bank_q[dec.sel[1:0]] <= wval;
        RC_CMD:  cmd_q[dec.sel[0]] <= wval & CMD_MASK;
        RC_CFGA: cfga_q <= wval & CFGA_MASK;
        default: ;
      endcase
    end
  end

  // decode windows: low, high and remap per window
  logic [NUM_WIN-1:0][LOW_W-1:0]   low_q;
  logic [NUM_WIN-1:0][HIGH_W-1:0]  high_q;
  logic [NUM_WIN-1:0][REMAP_W-1:0] remap_q;
  logic [NUM_WIN-1:0] low_hit, high_hit, remap_hit;

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    logic [LOW_W-1:0]   low_r;
    logic [HIGH_W-1:0]  high_r;
    logic [REMAP_W-1:0] remap_r;

    assign low_hit[k]   = wr_ev && (dec.cls == RC_LOW)   && (dec.sel == 3'(k));
    assign high_hit[k]  = wr_ev && (dec.cls == RC_HIGH)  && (dec.sel == 3'(k));
    assign remap_hit[k] = wr_ev && (dec.cls == RC_REMAP) && (dec.sel == 3'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        low_r   <= low_rst(k);
        high_r  <= high_rst(k);
        remap_r <= REMAP_W'(low_rst(k));
      end else begin
        if (low_hit[k]) begin
          low_r   <= wval[LOW_W-1:0];
          remap_r <= wval[REMAP_W-1:0];
        end else if (remap_hit[k]) begin
          remap_r <= wval[REMAP_W-1:0];
        end
        if (high_hit[k]) high_r <= wval[HIGH_W-1:0];
      end
    end

    assign low_q[k]   = low_r;
    assign high_q[k]  = high_r;
    assign remap_q[k] = remap_r;

    // R2
    remap_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      low_hit[k] |=> (remap_r == $past(wval[REMAP_W-1:0])));
  end

  hbr_window #(.LOW_W(LOW_W), .HIGH_W(HIGH_W), .SHIFT(WIN_SHIFT), .WIN_W(WIN_W)) u_window (
    .low(low_q[IO_WIN]), .high(high_q[IO_WIN]), .base(io_base), .size(io_size)
  );

  // read path
  logic [WORD_W-1:0] rd_raw, rd_out;
  always_comb begin
    rd_raw = '0;
    case (dec.cls)
      RC_CPU:   rd_raw = cpu_q;
      RC_LOW:   rd_raw = WORD_W'(low_q[dec.sel]);
      RC_HIGH:  rd_raw = WORD_W'(high_q[dec.sel]);
      RC_REMAP: rd_raw = WORD_W'(remap_q[dec.sel]);
      RC_ERR:   rd_raw = err_value(dec.sel);
      RC_SYNC:  rd_raw = SYNC_MARK;
      RC_BANK:  rd_raw = bank_q[dec.sel[1:0]];
      RC_CMD:   rd_raw = cmd_q[dec.sel[0]];
      RC_CFGA:  rd_raw = cfga_q;
      default:  rd_raw = '0;
    endcase
  end

  hbr_byteorder #(.W(WORD_W), .SWAP(BIG_ENDIAN)) u_rd_order (.din(rd_raw), .dout(rd_out));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_ev;
      if (rd_ev) rdata <= rd_out;
    end
  end

  logic win_touch;
  assign win_touch = wr_ev && ((dec.cls == RC_LOW) || (dec.cls == RC_HIGH));

  // R9
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ev |=> rvalid);

  // R9
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ev |=> !rvalid);

  // R6
  sync_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && dec.cls == RC_SYNC) |=> (rdata == SYNC_SEEN));

  // R7
  window_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && !win_touch) |=> ($stable(io_base) && $stable(io_size)));
endmodule

// File: tb/hbr_regfile_bench.sv
module hbr_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_le, rdata_be;
  logic        rvalid_le, rvalid_be;
  logic [35:0] base_le, size_le, base_be, size_be;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hbr_regfile u_hbr_regfile (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata_le), .rvalid(rvalid_le), .io_base(base_le), .io_size(size_le)
  );

  hbr_regfile #(.BIG_ENDIAN(1'b1)) u_hbr_regfile_be (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata_be), .rvalid(rvalid_be), .io_base(base_be), .io_size(size_be)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [31:0] a, output logic [31:0] le, output logic [31:0] be);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    le = rdata_le;
    be = rdata_be;
    chk("R9 rvalid after read", 64'(rvalid_le), 64'd1);
  endtask

  task automatic t_reset();
    logic [31:0] le, be;
    chk("R9 rvalid idle", 64'(rvalid_le), 64'd0);
    bus_rd(32'h000, le, be);
    chk("R8 cpu cfg LE", 64'(le), 64'h800);
    chk("R8 cpu cfg BE", 64'(be), 64'h0);
    bus_rd(32'h048, le, be); chk("R8 low0", 64'(le), 64'h80);
    bus_rd(32'h050, le, be); chk("R8 high0", 64'(le), 64'h0F);
    bus_rd(32'hC80, le, be);
    chk("R8 cmd1 LE", 64'(le), 64'h0001_0001);
    chk("R8 cmd1 BE", 64'(be), 64'h0);
    bus_rd(32'h458, le, be); chk("R8 bank3", 64'(le), 64'h5);
    bus_rd(32'hCF8, le, be); chk("R8 latch", 64'(le), 64'h0);
    chk("R7 reset base", 64'(base_le), 64'h0000_0000_1000_0000);
    chk("R7 reset size", 64'(size_le), 64'h0000_0000_0200_0000);
  endtask

  task automatic t_low_mirror();
    logic [31:0] le, be;
    bus_wr(32'h048, 32'hFFFF_FFFF);
    bus_rd(32'h048, le, be); chk("R2 low0 mask", 64'(le), 64'h7FFF);
    bus_rd(32'h0F0, le, be); chk("R2 remap0 mirror", 64'(le), 64'h7FF);
    bus_wr(32'h0B0, 32'h1234_5678);
    bus_rd(32'h0B0, le, be); chk("R2 low5 mask", 64'(le), 64'h5678);
    bus_rd(32'h118, le, be); chk("R2 remap5 mirror", 64'(le), 64'h678);
  endtask

  task automatic t_high_remap();
    logic [31:0] le, be;
    bus_wr(32'h050, 32'hFFFF_FF8A);
    bus_rd(32'h050, le, be); chk("R3 high0 mask", 64'(le), 64'h0A);
    bus_wr(32'h0F0, 32'hFFFF_F9AB);
    bus_rd(32'h0F0, le, be); chk("R3 remap direct", 64'(le), 64'h1AB);
    bus_rd(32'h048, le, be); chk("R3 low kept", 64'(le), 64'h7FFF);
  endtask

  task automatic t_window();
    bus_wr(32'h048, 32'h0000_0085);
    bus_wr(32'h050, 32'h0000_000A);
    chk("R7 base", 64'(base_le), 64'h85 * 64'd2097152);
    chk("R7 size", 64'(size_le), (64'd11 - 64'd5) * 64'd2097152);
    bus_wr(32'h048, 32'h0000_007F);
    bus_wr(32'h050, 32'h0000_0000);
    chk("R7 base wrap", 64'(base_le), 64'h7F * 64'd2097152);
    chk("R7 size wrap", 64'(size_le), 64'h10_0000_0000 - 64'd126 * 64'd2097152);
    bus_wr(32'h0C0, 32'h0000_0001);
    bus_wr(32'h138, 32'h0000_0002);
    chk("R5 base after ignored write", 64'(base_le), 64'h7F * 64'd2097152);
    chk("R5 size after ignored write", 64'(size_le), 64'h10_0000_0000 - 64'd126 * 64'd2097152);
  endtask

  task automatic t_masks();
    logic [31:0] le, be;
    bus_wr(32'hC00, 32'hFFFF_FFFF);
    bus_rd(32'hC00, le, be); chk("R4 cmd0 mask", 64'(le), 64'h0401_FC0F);
    bus_wr(32'hC80, 32'h1234_5678);
    bus_rd(32'hC80, le, be); chk("R4 cmd1 mask", 64'(le), 64'h0000_5408);
    bus_wr(32'hCF8, 32'hFFFF_FFFF);
    bus_rd(32'hCF8, le, be); chk("R4 latch mask", 64'(le), 64'h80FF_FFFC);
  endtask

  task automatic t_readonly();
    logic [31:0] le, be;
    bus_wr(32'h070, 32'h1234_5678);
    bus_wr(32'h128, 32'h1234_5678);
    bus_wr(32'h138, 32'h1234_5678);
    bus_wr(32'h120, 32'h1234_5678);
    bus_wr(32'h480, 32'h1234_5678);
    bus_rd(32'h070, le, be); chk("R5 err addr lo", 64'(le), 64'h0);
    bus_rd(32'h128, le, be); chk("R5 err data lo", 64'(le), 64'hFFFF_FFFF);
    bus_rd(32'h130, le, be); chk("R5 err data hi", 64'(le), 64'hFFFF_FFFF);
    bus_rd(32'h138, le, be); chk("R5 err parity", 64'(le), 64'hFF);
    bus_rd(32'h120, le, be); chk("R5 multi", 64'(le), 64'h0);
    bus_rd(32'h480, le, be); chk("R5 ecc", 64'(le), 64'h0);
  endtask

  task automatic t_sync();
    logic [31:0] le, be;
    bus_rd(32'h0C0, le, be);
    chk("R6 sync0", 64'(le), 64'hC000_FFEE);
    bus_rd(32'h0C8, le, be);
    chk("R6 sync1", 64'(le), 64'hC000_FFEE);
    chk("R11 sync swapped", 64'(be), 64'hEEFF_00C0);
  endtask

  task automatic t_alias();
    logic [31:0] le, be;
    bus_wr(32'h0000_1CF8, 32'h8000_0004);
    bus_rd(32'h0000_0CF8, le, be); chk("R1 alias write", 64'(le), 64'h8000_0004);
    bus_rd(32'hFFFF_FCFB, le, be); chk("R1 alias read", 64'(le), 64'h8000_0004);
  endtask

  task automatic t_plain();
    logic [31:0] le, be;
    bus_wr(32'h000, 32'hDEAD_BEEF);
    bus_rd(32'h000, le, be); chk("R10 cpu cfg full", 64'(le), 64'hDEAD_BEEF);
    bus_wr(32'h458, 32'hA5A5_0003);
    bus_rd(32'h458, le, be); chk("R10 bank full", 64'(le), 64'hA5A5_0003);
    bus_wr(32'h800, 32'h0000_1234);
    bus_rd(32'h800, le, be); chk("R10 unlisted", 64'(le), 64'h0);
    bus_rd(32'hCFC, le, be); chk("R10 cfg data slot", 64'(le), 64'h0);
  endtask

  task automatic t_big_endian();
    logic [31:0] le, be;
    bus_wr(32'h048, 32'h2211_0000);
    bus_rd(32'h048, le, be); chk("R11 low BE", 64'(be), 64'h2211_0000);
    bus_rd(32'h0F0, le, be); chk("R11 remap BE", 64'(be), 64'h2201_0000);
    chk("R11 base BE", 64'(base_be), 64'h1122 * 64'd2097152);
    bus_rd(32'h138, le, be); chk("R11 parity BE", 64'(be), 64'hFF00_0000);
  endtask

  task automatic t_write_no_valid();
    bus_wr(32'h000, 32'h1);
    chk("R9 no rvalid after write", 64'(rvalid_le), 64'd0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_low_mirror();
    t_high_remap();
    t_window();
    t_masks();
    t_readonly();
    t_sync();
    t_alias();
    t_plain();
    t_big_endian();
    t_write_no_valid();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end
endmodule